// File: doc/BRIEF.md
# Clock-synchronous serial I/O unit

This block is an 8-bit synchronous serial transceiver with a single shift register. A write to the data register starts a transfer. Each bit of that byte is shifted out on the serial output while the serial input is shifted into the same register, so the received byte can be read from the data register once the transfer ends. The transfer clock comes from one of two places. It can come from an on-block divider, which runs from one of three prescaled enable strobes and drives the clock pin. It can also come from an external clock pin, which the block watches through a synchronizer.

A control register selects the clock source, the bit order, the clock polarity and the idle output level used with an external clock. When the eighth bit has been sampled, the block raises a one-cycle completion interrupt and drops its busy flag. With the internal clock the serial output is released to high impedance half a transfer clock after the last bit.

Top module: `sio_unit`

## Requirements
- R1: In internal clock mode the transfer clock changes level after every n+1 strobes of the selected source, where n is the 8-bit divider value (0..255). The period is therefore 2(n+1) strobes.
- R2: In internal clock mode exactly eight pulses are produced per transfer. Between transfers the clock rests at the inverse of the polarity bit: high for polarity 0 and low for polarity 1.
- R3: `irq` is a one-cycle pulse that follows the eighth sampling edge. That edge is rising for polarity 0 and falling for polarity 1. `busy` is high from the data write until that pulse, and falls together with it.
- R4: The bit order is set by control bit 3 (0 = LSB first, 1 = MSB first) and applies to both directions. After a transfer, `dat_rdata` holds the received byte.
- R5: The output bit changes on the leading clock edge, away from the rest level. The input is sampled on the trailing edge. The first bit appears at the first leading edge.
- R6: In internal clock mode `sdo_oe` rises at the first leading edge. It stays high for one half period after the last sampling edge, with the last bit held, and then falls.
- R7: A data write during that hold window drops `sdo_oe` on the next cycle.
- R8: In external clock mode `sdo_oe` is always high. Between transfers, and before the first leading edge, `sdo` takes the level of control bit 5.
- R9: In external clock mode every further clock pulse shifts the register again, but no second `irq` is raised.
- R10: Control bits [1:0] select the strobe that feeds the divider: 0 = `tick_a`, 1 = `tick_b`, 2 = `tick_c`. Control bit 2 = 1 selects the internal clock, and bit 4 is the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Prescaled strobe, source 0 |
| tick_b | input | 1 | Prescaled strobe, source 1 |
| tick_c | input | 1 | Prescaled strobe, source 2 |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 6 | Control value: [1:0] source, [2] internal clock, [3] MSB first, [4] polarity, [5] idle level |
| div_we | input | 1 | Divider register write |
| div_wdata | input | 8 | Divider value n |
| dat_we | input | 1 | Data write, starts a transfer |
| dat_wdata | input | 8 | Byte to send |
| dat_rdata | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion pulse |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Transfer clock driven by the block |
| sclk_oe | output | 1 | Clock pin drive enable (internal mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial output drive enable |

## Verification
The two functions that can coincide are the end of the half-period hold window and a new data write. Both can land on the same clock: the divider strobe that would close the hold window, and the write that must release the output at once and restart the divider. The bench provokes this by writing fresh data one cycle after `busy` falls, while the output is still holding the last bit of a transfer driven by a small divider. It then judges `sdo_oe` on the very next cycle. A per-cycle reference model, counting source strobes since the write, then checks that the second transfer starts cleanly.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        SRC_A   = 2'd0,
        SRC_B   = 2'd1,
        SRC_C   = 2'd2,
        SRC_OFF = 2'd3
    } sio_src_e;

    // Control word, bit 5 down to bit 0
    typedef struct packed {
        logic     idle_lvl;   // [5] output level between transfers (external clock)
        logic     pol;        // [4] clock polarity
        logic     msb_first;  // [3] bit order
        logic     int_clk;    // [2] 1: internal divider drives the clock
        sio_src_e src;        // [1:0] strobe select
    } sio_cfg_t;

    localparam int CTL_W = $bits(sio_cfg_t);

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             half
);
    logic [DIV_W-1:0] cnt;

    assign half = run && tick && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= '0;
        else if (tick)              cnt <= (cnt == div) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sio_engine.sv
module sio_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_clk,
    input  logic              pol,
    input  logic              msb_first,
    input  logic              idle_lvl,
    input  logic              ctl_we,
    input  logic              wr_pol,
    input  logic              wr_idle,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              half,
    input  logic              ext_lead,
    input  logic              ext_trail,
    input  logic              sdi_s,
    output logic [DATA_W-1:0] sr_q,
    output logic              obit,
    output logic              oe_q,
    output logic              sclk_q,
    output logic              busy,
    output logic              hold,
    output logic              irq
);
    localparam int             CNT_W = $clog2(DATA_W);
    localparam [CNT_W-1:0]     LAST  = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] nbit;
    logic             at_rest;

    function automatic logic pick(input logic [DATA_W-1:0] v, input logic m);
        return m ? v[DATA_W-1] : v[0];
    endfunction

    function automatic logic [DATA_W-1:0] push(input logic [DATA_W-1:0] v,
                                               input logic m, input logic b);
        return m ? {v[DATA_W-2:0], b} : {b, v[DATA_W-1:1]};
    endfunction

    assign at_rest = (sclk_q != pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            obit   <= 1'b0;
            oe_q   <= 1'b0;
            sclk_q <= 1'b1;
            busy   <= 1'b0;
            hold   <= 1'b0;
            irq    <= 1'b0;
            nbit   <= '0;
        end else begin
            irq <= 1'b0;
            if (ctl_we) begin
                sclk_q <= ~wr_pol;
                obit   <= wr_idle;
                oe_q   <= 1'b0;
                hold   <= 1'b0;
            end else if (dat_we) begin
                sr_q <= dat_wdata;
                busy <= 1'b1;
                nbit <= '0;
                hold <= 1'b0;
                if (int_clk) begin
                    oe_q   <= 1'b0;
                    sclk_q <= ~pol;
                end
            end else if (int_clk) begin
                if (half && busy) begin
                    if (at_rest) begin
                        sclk_q <= pol;
                        obit   <= pick(sr_q, msb_first);
                        oe_q   <= 1'b1;
                    end else begin
                        sclk_q <= ~pol;
                        sr_q   <= push(sr_q, msb_first, sdi_s);
                        nbit   <= nbit + 1'b1;
                        if (nbit == LAST) begin
                            busy <= 1'b0;
                            irq  <= 1'b1;
                            hold <= 1'b1;
                        end
                    end
                end else if (half && hold) begin
                    hold <= 1'b0;
                    oe_q <= 1'b0;
                end
            end else begin
                if (ext_lead) obit <= pick(sr_q, msb_first);
                if (ext_trail) begin
                    sr_q <= push(sr_q, msb_first, sdi_s);
                    if (busy) begin
                        nbit <= nbit + 1'b1;
                        if (nbit == LAST) begin
                            busy <= 1'b0;
                            irq  <= 1'b1;
                            obit <= idle_lvl;
                        end
                    end
                end
            end
        end
    end

    // R3
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R3
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);
endmodule

// File: rtl/sio_unit.sv
module sio_unit
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              tick_c,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] dat_rdata,
    output logic              busy,
    output logic              irq,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe
);
    sio_cfg_t         cfg, cfg_wr;
    logic [DIV_W-1:0] div_q;
    logic             tick_sel, half, hold, oe_q, obit, sclk_q;
    logic             sclk_s, sclk_p, sdi_s, ext_edge, ext_lead, ext_trail;

    assign cfg_wr = sio_cfg_t'(ctl_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            div_q  <= '0;
            sclk_p <= 1'b0;
        end else begin
            if (ctl_we) cfg   <= cfg_wr;
            if (div_we) div_q <= div_wdata;
            sclk_p <= sclk_s;
        end
    end

    always_comb begin
        unique case (cfg.src)
            SRC_A:   tick_sel = tick_a;
            SRC_B:   tick_sel = tick_b;
            SRC_C:   tick_sel = tick_c;
            default: tick_sel = 1'b0;
        endcase
    end

    sio_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst(rst), .d(sclk_in), .q(sclk_s));
    sio_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst(rst), .d(sdi), .q(sdi_s));

    assign ext_edge  = (sclk_s != sclk_p);
    assign ext_lead  = ext_edge && (sclk_s == cfg.pol);
    assign ext_trail = ext_edge && (sclk_s != cfg.pol);

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst),
        .run(cfg.int_clk && (busy || hold)),
        .restart(dat_we || ctl_we),
        .tick(tick_sel), .div(div_q), .half(half));

    sio_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst(rst),
        .int_clk(cfg.int_clk), .pol(cfg.pol), .msb_first(cfg.msb_first),
        .idle_lvl(cfg.idle_lvl),
        .ctl_we(ctl_we), .wr_pol(cfg_wr.pol), .wr_idle(cfg_wr.idle_lvl),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .half(half), .ext_lead(ext_lead), .ext_trail(ext_trail), .sdi_s(sdi_s),
        .sr_q(dat_rdata), .obit(obit), .oe_q(oe_q), .sclk_q(sclk_q),
        .busy(busy), .hold(hold), .irq(irq));

    assign sclk_out = cfg.int_clk ? sclk_q : ~cfg.pol;
    assign sclk_oe  = cfg.int_clk;
    assign sdo      = obit;
    assign sdo_oe   = cfg.int_clk ? oe_q : 1'b1;

    // R2
    clk_park_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.int_clk && !busy) |-> (sclk_out == !cfg.pol));

    // R5
    oe_on_lead_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sdo_oe) && cfg.int_clk) |-> (sclk_out == cfg.pol));

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sdo_oe) && cfg.int_clk && !$past(dat_we) && !$past(ctl_we)) |-> !busy);
endmodule

// File: tb/tb_sio_unit.sv
module tb_sio_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_a = 1'b1, tick_b = 1'b0, tick_c = 1'b0;
    logic       ctl_we = 1'b0, div_we = 1'b0, dat_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [7:0] div_wdata = '0, dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       busy, irq, sclk_in = 1'b1, sclk_out, sclk_oe, sdi = 1'b0, sdo, sdo_oe;

    sio_unit dut (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .tick_c(tick_c),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .div_we(div_we), .div_wdata(div_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .busy(busy), .irq(irq), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

    always #10 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0, wd = 0, irq_cnt = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", what, act, exp, $time);
        end
    endtask

    // strobes: a every cycle, b every 2nd, c every 4th
    always @(negedge clk) begin
        cyc++;
        tick_b = (cyc % 2 == 0);
        tick_c = (cyc % 4 == 0);
    end

    always @(posedge clk) if (!rst && irq) irq_cnt++;

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", wd);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- behavioural reference for internal-clock transfers
    bit       mdl_on = 0;
    int       m_src = 0, m_n = 0;
    bit       m_msb = 0, m_pol = 0;
    bit       m_act = 0, m_irq = 0;
    int       m_tc = 0, m_m = 0;
    bit [7:0] m_tx = 0, m_rx = 0;

    function automatic bit sel_tick();
        case (m_src)
            0: return tick_a;
            1: return tick_b;
            2: return tick_c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int bit_at(input int idx);
        return m_msb ? 7 - idx : idx;
    endfunction

    always @(posedge clk) begin
        m_irq = 0;
        if (rst) begin
            m_act = 0;
        end else if (dat_we) begin
            m_act = 1; m_tc = 0; m_m = 0; m_tx = dat_wdata;
        end else if (m_act && sel_tick()) begin
            m_tc++;
            if (m_tc == m_n + 1) begin
                m_tc = 0;
                m_m++;
                if (m_m == 16) m_irq = 1;
                if (m_m == 17) m_act = 0;
            end
        end
    end

    // drive serial input for the bit just started; compare every cycle
    always @(negedge clk) begin
        if (mdl_on) begin
            automatic bit  exp_busy = m_act && (m_m < 16);
            automatic bit  exp_sclk = (m_act && (m_m % 2 == 1)) ? m_pol : !m_pol;
            automatic bit  exp_oe   = m_act && (m_m >= 1);
            automatic int  idx      = (m_m >= 1) ? (m_m - 1) / 2 : 0;
            if (m_act && (m_m % 2 == 1)) sdi = m_rx[bit_at(idx)];
            chk(busy == exp_busy, "R3 busy", busy, exp_busy);
            chk(irq == m_irq, "R3 irq timing", irq, m_irq);
            chk(sclk_out == exp_sclk, "R1 R2 R10 sclk", sclk_out, exp_sclk);
            chk(sdo_oe == exp_oe, "R6 sdo_oe", sdo_oe, exp_oe);
            if (exp_oe) chk(sdo == m_tx[bit_at(idx)], "R5 R4 sdo bit", sdo, m_tx[bit_at(idx)]);
        end
    end

    task automatic wr_ctl(input bit [5:0] v);
        ctl_wdata = v; ctl_we = 1; @(negedge clk); ctl_we = 0;
    endtask
    task automatic wr_div(input bit [7:0] v);
        div_wdata = v; div_we = 1; @(negedge clk); div_we = 0;
    endtask
    task automatic wr_dat(input bit [7:0] v);
        dat_wdata = v; dat_we = 1; @(negedge clk); dat_we = 0;
    endtask

    // ctl: [5] idle, [4] pol, [3] msb, [2] internal, [1:0] source
    task automatic run_int(input int src, input int n, input bit msb, input bit pol,
                           input bit [7:0] tx, input bit [7:0] rx, input bit hold_wr);
        mdl_on = 0;
        @(negedge clk);
        wr_div(8'(n));
        wr_ctl({1'b0, pol, msb, 1'b1, 2'(src)});
        m_src = src; m_n = n; m_msb = msb; m_pol = pol; m_rx = rx;
        @(negedge clk);
        mdl_on = 1;
        wr_dat(tx);
        while (busy) @(negedge clk);
        if (hold_wr) begin
            // R7: write while the last bit is still held
            chk(sdo_oe == 1'b1, "R6 hold window open", sdo_oe, 1);
            dat_wdata = ~tx; dat_we = 1; @(negedge clk); dat_we = 0;
            chk(sdo_oe == 1'b0, "R7 release on write", sdo_oe, 0);
            while (busy) @(negedge clk);
        end
        while (m_act) @(negedge clk);
        chk(dat_rdata == rx, "R4 received byte", dat_rdata, rx);
        chk(sdo_oe == 1'b0, "R6 released after hold", sdo_oe, 0);
    endtask

    initial begin
        int irq0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        chk(busy == 0 && irq == 0, "R3 reset busy/irq", {busy, irq}, 0);
        chk(dat_rdata == 8'h00, "R4 reset data", dat_rdata, 0);
        chk(sdo_oe == 1 && sdo == 0, "R8 reset output idle", {sdo_oe, sdo}, 2);
        chk(sclk_oe == 0, "R10 reset external mode", sclk_oe, 0);

        // internal clock, various sources, orders and polarities (R10)
        run_int(0, 3, 0, 0, 8'hA5, 8'h3C, 0);
        run_int(1, 2, 1, 1, 8'h96, 8'hC1, 0);
        run_int(2, 0, 0, 1, 8'h5E, 8'h81, 0);
        run_int(0, 255, 1, 0, 8'h0F, 8'hE7, 0);
        run_int(0, 5, 1, 0, 8'h71, 8'h4B, 1);
        mdl_on = 0;

        // external clock, idle level 1, polarity 0, LSB first
        wr_ctl(6'b10_0_0_0_0 | 6'h20);
        repeat (3) @(negedge clk);
        chk(sdo_oe == 1 && sdo == 1, "R8 idle level high", {sdo_oe, sdo}, 3);
        irq0 = irq_cnt;
        wr_dat(8'h6D);
        repeat (2) @(negedge clk);
        chk(sdo == 1, "R8 idle before first edge", sdo, 1);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 0; sdi = 8'hB2 >> i;
            repeat (6) @(negedge clk);
            chk(sdo == ((8'h6D >> i) & 1), "R5 R4 external out bit", sdo, (8'h6D >> i) & 1);
            chk(busy == 1, "R3 busy during external", busy, 1);
            sclk_in = 1;
            repeat (6) @(negedge clk);
        end
        chk(irq_cnt == irq0 + 1, "R3 one completion pulse", irq_cnt - irq0, 1);
        chk(busy == 0, "R3 busy cleared", busy, 0);
        chk(dat_rdata == 8'hB2, "R4 external received", dat_rdata, 8'hB2);
        chk(sdo == 1 && sdo_oe == 1, "R8 idle after transfer", {sdo_oe, sdo}, 3);
        // ninth pulse
        sclk_in = 0; sdi = 1;
        repeat (6) @(negedge clk);
        sclk_in = 1;
        repeat (6) @(negedge clk);
        chk(dat_rdata == 8'hD9, "R9 extra pulse shifts", dat_rdata, 8'hD9);
        chk(irq_cnt == irq0 + 1, "R9 no second pulse", irq_cnt - irq0, 1);
        // idle level 0
        wr_ctl(6'h00);
        repeat (2) @(negedge clk);
        chk(sdo == 0 && sdo_oe == 1, "R8 idle level low", {sdo_oe, sdo}, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule